// File: doc/BRIEF.md
# Weighted Round Queue Scheduler

This block chooses which of up to eight command queues feeding a single output port is served next. Each queue has a 4-bit priority setting. Settings 0 through 8 give the queue a fixed participation pattern over a cycle of eight rounds, so a queue takes part only in the rounds its pattern enables. Setting 9 makes the queue a strict-priority queue. Strict-priority queues with work always win over weighted queues, and among them the lowest index wins.

Inside a round, the eligible weighted queues are served in round-robin order. The search starts just after the queue that was granted last. Once every eligible queue in the round has been served, or when no queue is eligible in the round, the scheduler moves to the next round. A grant is one-hot and registered. It is held until the consumer accepts it. The priority vector can be rewritten while the scheduler runs. A combinational flag reports priority vectors that break the configuration rules.

Top module: `qsched_wrr`

## Requirements
- R1: A weighted queue at setting s (0 to 8) takes part in round r (0 to 7) only if bit r of its pattern is set. The patterns are: setting 0 = 0x00, 1 = 0x01, 2 = 0x11, 3 = 0x49, 4 = 0x55, 5 = 0x57, 6 = 0x77, 7 = 0x7F, 8 = 0xFF. Bit r of the pattern corresponds to round r.
- R2: A queue at setting 0 is never granted, even when it is non-empty.
- R3: Setting 9 marks a queue as strict-priority. Among the non-empty strict-priority queues, the lowest index is granted, and it is granted ahead of any weighted queue.
- R4: A weighted queue is granted only when no strict-priority queue is non-empty at the decision.
- R5: Within a round, weighted grants go round-robin. The search starts at the index after the last weighted grant and wraps from NQ-1 to 0. Each queue is granted at most once per round. When no queue that has not yet been granted is eligible, the round advances by one (mod 8), and that decision cycle issues no grant.
- R6: `config_error` is high in the same cycle whenever the set of setting-9 queues is non-empty and is not a contiguous run starting at index 0.
- R7: `config_error` is high in the same cycle whenever any setting is 10 to 15. Such a queue is scheduled as weighted with pattern 0xFF.
- R8: `grant` is one-hot or zero. `grant_valid` is high exactly when `grant` is non-zero. A valid grant stays unchanged until `grant_ack` is sampled high.
- R9: Synchronous reset clears the grant and sets round 0 with the round-robin start at queue 0. The first decision is made at the first clock edge after reset is released.
- R10: A change to `q_prio` takes effect at the next decision, without reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_nonempty | input | NQ | Per-queue work-pending flags |
| q_prio | input | 4*NQ | Per-queue settings; queue i in bits [4i+3:4i] |
| grant_ack | input | 1 | Consumer takes the current grant |
| grant | output | NQ | One-hot registered grant |
| grant_valid | output | 1 | A grant is being offered |
| config_error | output | 1 | Priority vector breaks the configuration rules |

## Verification
The scheduler is driven with all eight weights at once, with sparse patterns that mix zero and full weights, and with strict-priority prefixes in which the leading queues are empty or full. These separate the pattern table, the zero-weight exclusion and the strict-over-weighted ordering. Illegal vectors are also applied: a prefix that does not start at queue 0, a gapped run, and an out-of-range setting. They show that the error flag rises and that the out-of-range queue still behaves as full weight. Held grants with the accept signal low, and a priority rewrite in mid-run, show grant stability and live reconfiguration. Every grant is compared with a cycle model kept in the bench.

// File: rtl/qsched_pkg.sv
package qsched_pkg;

    localparam int PRIO_W     = 4;
    localparam int ROUNDS     = 8;
    localparam int RND_W      = $clog2(ROUNDS);
    localparam logic [PRIO_W-1:0] PRIO_STRICT = 4'd9;

    typedef logic [ROUNDS-1:0] rmask_t;

    typedef struct packed {
        rmask_t mask;
        logic   strict;
        logic   invalid;
    } qcfg_t;

    function automatic rmask_t prio_to_mask(input logic [PRIO_W-1:0] p);
        rmask_t m;
        case (p)
            4'd0:    m = 8'h00;
            4'd1:    m = 8'h01;
            4'd2:    m = 8'h11;
            4'd3:    m = 8'h49;
            4'd4:    m = 8'h55;
            4'd5:    m = 8'h57;
            4'd6:    m = 8'h77;
            4'd7:    m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

    function automatic qcfg_t decode_prio(input logic [PRIO_W-1:0] p);
        qcfg_t c;
        c.mask    = prio_to_mask(p);
        c.strict  = (p == PRIO_STRICT);
        c.invalid = (p > PRIO_STRICT);
        return c;
    endfunction

endpackage

// File: rtl/qsched_cfg_decode.sv
module qsched_cfg_decode
    import qsched_pkg::*;
#(
    parameter int NQ = 8
) (
    input  logic [NQ*PRIO_W-1:0] q_prio,
    output logic [NQ*ROUNDS-1:0] mask_flat,
    output logic [NQ-1:0]        strict_vec,
    output logic                 config_error
);
    logic [NQ-1:0] invalid_vec;
    logic [NQ-1:0] strict_plus;

    for (genvar i = 0; i < NQ; i++) begin : g_q
        qcfg_t cfg;
        always_comb begin
            cfg = decode_prio(q_prio[i*PRIO_W +: PRIO_W]);
        end
        assign mask_flat[i*ROUNDS +: ROUNDS] = cfg.mask;
        assign strict_vec[i]                 = cfg.strict;
        assign invalid_vec[i]                = cfg.invalid;
    end

    // A run starting at bit 0 plus one has no bit in common with itself.
    assign strict_plus  = strict_vec + 1'b1;
    assign config_error = (|invalid_vec) || ((strict_vec & strict_plus) != '0);

endmodule

// File: rtl/qsched_rr_pick.sv
module qsched_rr_pick #(
    parameter int NQ = 8,
    localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic [NQ-1:0] req,
    input  logic [IW-1:0] start,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < NQ; k++) begin
            int j;
            j = int'(start) + k;
            if (j >= NQ) j = j - NQ;
            if (!hit && req[j]) begin
                hit = 1'b1;
                idx = IW'(j);
            end
        end
    end
endmodule

// File: rtl/qsched_wrr.sv
module qsched_wrr
    import qsched_pkg::*;
#(
    parameter int NQ = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NQ-1:0]        q_nonempty,
    input  logic [NQ*PRIO_W-1:0] q_prio,
    input  logic                 grant_ack,
    output logic [NQ-1:0]        grant,
    output logic                 grant_valid,
    output logic                 config_error
);
    localparam int IW = (NQ > 1) ? $clog2(NQ) : 1;

    logic [NQ*ROUNDS-1:0] mask_flat;
    logic [NQ-1:0]        strict_vec;
    logic [NQ-1:0]        strict_req;
    logic [NQ-1:0]        weight_req;
    logic                 st_hit, wt_hit;
    logic [IW-1:0]        st_idx, wt_idx;

    logic [NQ-1:0]        gnt_q;
    logic                 gvalid_q;
    logic [RND_W-1:0]     round_q;
    logic [IW-1:0]        ptr_q;
    logic [NQ-1:0]        visited_q;
    logic                 decide;

    qsched_cfg_decode #(.NQ(NQ)) cfg_i (
        .q_prio       (q_prio),
        .mask_flat    (mask_flat),
        .strict_vec   (strict_vec),
        .config_error (config_error)
    );

    for (genvar i = 0; i < NQ; i++) begin : g_req
        assign strict_req[i] = q_nonempty[i] & strict_vec[i];
        assign weight_req[i] = q_nonempty[i] & ~strict_vec[i] & ~visited_q[i]
                             & mask_flat[i*ROUNDS + int'(round_q)];
    end

    qsched_rr_pick #(.NQ(NQ)) st_pick_i (
        .req   (strict_req),
        .start ('0),
        .hit   (st_hit),
        .idx   (st_idx)
    );

    qsched_rr_pick #(.NQ(NQ)) wt_pick_i (
        .req   (weight_req),
        .start (ptr_q),
        .hit   (wt_hit),
        .idx   (wt_idx)
    );

    assign decide = !gvalid_q || grant_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q     <= '0;
            gvalid_q  <= 1'b0;
            round_q   <= '0;
            ptr_q     <= '0;
            visited_q <= '0;
        end else if (decide) begin
            if (st_hit) begin
                gnt_q    <= NQ'(1) << st_idx;
                gvalid_q <= 1'b1;
            end else if (wt_hit) begin
                gnt_q     <= NQ'(1) << wt_idx;
                gvalid_q  <= 1'b1;
                visited_q <= visited_q | (NQ'(1) << wt_idx);
                ptr_q     <= (int'(wt_idx) == NQ - 1) ? '0 : wt_idx + 1'b1;
            end else begin
                gnt_q     <= '0;
                gvalid_q  <= 1'b0;
                round_q   <= round_q + 1'b1;
                visited_q <= '0;
            end
        end
    end

    assign grant       = gnt_q;
    assign grant_valid = gvalid_q;

endmodule

// File: rtl/qsched_wrr_chk.sv
module qsched_wrr_chk
    import qsched_pkg::*;
#(
    parameter int NQ = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NQ-1:0]        q_nonempty,
    input logic [NQ*PRIO_W-1:0] q_prio,
    input logic                 grant_ack,
    input logic [NQ-1:0]        grant,
    input logic                 grant_valid
);
    logic [NQ-1:0] st_ne;
    logic [NQ-1:0] zero_w;

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            st_ne[i]  = q_nonempty[i] && (q_prio[i*PRIO_W +: PRIO_W] == 4'd9);
            zero_w[i] = (q_prio[i*PRIO_W +: PRIO_W] == 4'd0);
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (grant_valid == (grant != '0)));                         // R8

    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        grant_valid && !grant_ack |=> grant_valid && $stable(grant));               // R8

    AST_STRICT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid || grant_ack) && (st_ne != '0) |=> (grant & $past(st_ne)) != '0); // R3

    AST_ZERO_NEVER: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid || grant_ack) |=> (grant & $past(zero_w)) == '0);             // R2

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !grant_valid && (grant == '0));                                     // R9

endmodule

bind qsched_wrr qsched_wrr_chk #(.NQ(NQ)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .q_nonempty  (q_nonempty),
    .q_prio      (q_prio),
    .grant_ack   (grant_ack),
    .grant       (grant),
    .grant_valid (grant_valid)
);

// File: tb/qsched_wrr_tb.sv
`timescale 1ns/1ps
module qsched_wrr_tb_top;
    localparam int NQ = 8;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NQ-1:0] q_nonempty = '0;
    logic [NQ*4-1:0] q_prio = '0;
    logic          grant_ack = 1'b0;
    logic [NQ-1:0] grant;
    logic          grant_valid;
    logic          config_error;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    qsched_wrr #(.NQ(NQ)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .q_nonempty   (q_nonempty),
        .q_prio       (q_prio),
        .grant_ack    (grant_ack),
        .grant        (grant),
        .grant_valid  (grant_valid),
        .config_error (config_error)
    );

    // Stimulus table: priority vector, non-empty flags, expected error flag, tag
    localparam logic [31:0] T_PRIO [NV] = '{
        32'h8765_4321, 32'h0000_8080, 32'h4444_4499, 32'h4444_4499, 32'h4444_4499,
        32'h0000_0090, 32'h0000_0909, 32'h0000_A111, 32'h9999_9999, 32'h0000_0000,
        32'h8888_8888 };
    localparam logic [7:0] T_NE [NV] = '{
        8'hFF, 8'h0F, 8'hFF, 8'hFE, 8'hFC, 8'h03, 8'h07, 8'h0F, 8'h80, 8'hFF, 8'hAA };
    localparam logic T_ERR [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0 };
    localparam string T_TAG [NV] = '{
        "R1", "R2", "R3", "R3", "R4", "R6", "R6", "R7", "R3", "R2", "R5" };

    // Cycle model built from the requirements
    int m_valid, m_gnt, m_round, m_ptr;
    logic [NQ-1:0] m_vis;

    function automatic logic [7:0] pat(input logic [3:0] s);
        case (s)
            4'd0: return 8'h00;  4'd1: return 8'h01;  4'd2: return 8'h11;
            4'd3: return 8'h49;  4'd4: return 8'h55;  4'd5: return 8'h57;
            4'd6: return 8'h77;  4'd7: return 8'h7F;  default: return 8'hFF;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0; m_gnt = 0; m_round = 0; m_ptr = 0; m_vis = '0;
        end else if (m_valid == 0 || grant_ack) begin
            int st, w;
            st = -1; w = -1;
            for (int i = 0; i < NQ; i++)
                if (st < 0 && q_nonempty[i] && q_prio[i*4 +: 4] == 4'd9) st = i;
            if (st >= 0) begin
                m_gnt = st; m_valid = 1;
            end else begin
                for (int k = 0; k < NQ; k++) begin
                    int j;
                    j = (m_ptr + k) % NQ;
                    if (w < 0 && q_nonempty[j] && q_prio[j*4 +: 4] != 4'd9 &&
                        pat(q_prio[j*4 +: 4])[m_round] && !m_vis[j]) w = j;
                end
                if (w >= 0) begin
                    m_gnt = w; m_valid = 1; m_vis[w] = 1'b1; m_ptr = (w + 1) % NQ;
                end else begin
                    m_valid = 0; m_round = (m_round + 1) % 8; m_vis = '0;
                end
            end
        end
    end

    task automatic check_grant(input string tag);
        logic [NQ-1:0] exp_g;
        exp_g = (m_valid != 0) ? (NQ'(1) << m_gnt) : '0;
        checks++;
        if (grant !== exp_g || grant_valid !== (m_valid != 0)) begin
            fails++;
            $display("FAIL %s grant actual=%b/%b expected=%b/%b", tag,
                     grant, grant_valid, exp_g, m_valid != 0);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp_v);
        end
    endtask

    task automatic do_reset(input logic [31:0] p, input logic [7:0] ne);
        @(negedge clk);
        rst = 1'b1; q_prio = p; q_nonempty = ne; grant_ack = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n, input string tag);
        repeat (n) begin
            @(negedge clk);
            check_grant(tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Table walk
        for (int v = 0; v < NV; v++) begin
            do_reset(T_PRIO[v], T_NE[v]);
            check_bit({T_TAG[v], " config_error"}, config_error, T_ERR[v]);
            run(48, T_TAG[v]);
        end

        // R9: reset state and first decision
        @(negedge clk);
        rst = 1'b1; q_prio = 32'h8888_8888; q_nonempty = 8'hFF; grant_ack = 1'b0;
        repeat (2) @(negedge clk);
        check_bit("R9 grant_valid in reset", grant_valid, 1'b0);
        check_bit("R9 grant zero in reset", grant == '0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R9 first grant to queue 0", grant[0] && grant_valid, 1'b1);

        // R8: grant held while accept is low
        repeat (4) begin
            @(negedge clk);
            check_bit("R8 grant held", grant[0] && grant_valid, 1'b1);
        end
        grant_ack = 1'b1;
        @(negedge clk);
        check_bit("R8 next grant after accept", grant[1], 1'b1);
        check_grant("R8");

        // R10: rewrite priorities while running
        run(5, "R10");
        q_prio = 32'h0080_0000;
        run(30, "R10");
        q_prio = 32'h0000_0099;
        run(10, "R10");
        check_bit("R10 config_error after rewrite", config_error, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule